// File: doc/BRIEF.md
# Posted-Write Register Bridge Between Bus and Slow Timer Clock

This block is the bus-facing register front end of a timer. The bus runs on a fast clock. The timer's working registers live on a slow clock of roughly 32 kHz. Ten of the registers must reach the slow domain. Each of them has its own holding register, its own toggle request and acknowledge pair, and its own pending flag. Software can read all ten flags at once through a read-only status word. The other registers are plain storage on the bus side and take no part in the crossing.

One bit of the interface-control register selects the mode. In posted mode, a write to a synchronised register completes in one bus cycle. The value then crosses in the background, and the bus can go on to other registers. A second write to the same register while its flag is still set is dropped and raises a sticky error. In non-posted mode, the bus ready signal is held low until the value has landed and the acknowledge has come back. A read of a synchronised register while its own write is still in flight raises a second sticky error.

On the slow side, each register has an update strobe that pulses for one slow-clock cycle. Its captured data word stays stable until the next update.

Top module: `posted_reg_bridge`

## Requirements
- R1: After reset the status word at 0x34 reads 0, the interface-control word at 0x40 reads 0x4 (bit 2 = 1 selects posted mode), both error flags are 0 and bus_ready is high.
- R2: In posted mode a write to a synchronised register completes with bus_ready high in its first cycle. From the next cycle on, the register's bit is set in the status word. The bit positions are: 0x24→0, 0x28→1, 0x2C→2, 0x30→3, 0x38→4, 0x48→5, 0x4C→6, 0x50→7, 0x54→8, 0x58→9.
- R3: An accepted write produces exactly one one-slow-cycle pulse on that register's f_strobe bit, with f_data slice i equal to the written word. The pending bit then clears, within 60 bus cycles at the nominal clock ratio.
- R4: In posted mode a write to a register whose pending bit is set is dropped: it is not delivered, the earlier value stays, and wr_drop_err is set and remains set until reset.
- R5: A read of a synchronised register whose pending bit is set sets the sticky rd_pend_err. A read while the bit is clear does not set it.
- R6: With bit 2 of 0x40 cleared (non-posted mode), a write to a synchronised register holds bus_ready low until the update has landed. When the write completes, the status bit is already clear.
- R7: Registers 0x00, 0x10, 0x14, 0x18, 0x1C, 0x20, 0x3C, 0x40 and 0x44 are written directly. A value written there reads back on the next access, sets no pending bit, pulses no strobe and never stalls, in either mode.
- R8: Pending flags are independent. Back-to-back writes to different synchronised registers are all accepted and all delivered with their own data.
- R9: A read of a synchronised register returns the last accepted write data.
- R10: The status word at 0x34 is read-only. A write to it changes no flag and delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain; re-synchronised into the slow domain |
| bus_valid | input | 1 | Bus access request; held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while bus_valid is high and bus_we is low |
| bus_ready | output | 1 | Access completes at a clock edge where bus_valid and bus_ready are both high |
| fclk | input | 1 | Slow functional clock |
| f_strobe | output | 10 | Per-register update pulse, slow domain |
| f_data | output | 10*DW | Per-register captured data, slice i for flag bit i |
| wr_drop_err | output | 1 | Sticky: a posted write was dropped |
| rd_pend_err | output | 1 | Sticky: a register was read while its write was pending |

## Verification
A pending bit appears one bus cycle after the write is accepted. Error flags appear in the bus cycle after the offending access. The bench samples every one of these results at the falling edge that follows that rising edge. Delivery crosses clocks, so its timing varies. The bench therefore polls the status word every bus cycle, requires the bit to clear within a fixed bound, and waits a few slow cycles before it compares the strobe counts and data. The strobe counts and data come from a monitor sampling at the slow falling edge. In non-posted mode the bench counts the cycles with bus_ready low and checks that the status word is clear on the very next access.

// File: rtl/prb_pkg.sv
package prb_pkg;
  localparam int ADDR_W     = 8;
  localparam int NSYNC      = 10;
  localparam int NDIR       = 9;
  localparam int SIDX_W     = $clog2(NSYNC);
  localparam int DIDX_W     = $clog2(NDIR);
  localparam int IFC_IDX    = 8;
  localparam int POSTED_BIT = 2;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h34;

  typedef struct packed {
    logic              hit;
    logic [SIDX_W-1:0] idx;
  } sync_hit_t;

  typedef struct packed {
    logic              hit;
    logic [DIDX_W-1:0] idx;
  } dir_hit_t;

  // flag bit order is decoded by software through the status word
  function automatic sync_hit_t sync_lookup(input logic [ADDR_W-1:0] a);
    sync_hit_t r;
    r.hit = 1'b1;
    case (a)
      8'h24:   r.idx = 4'd0;
      8'h28:   r.idx = 4'd1;
      8'h2C:   r.idx = 4'd2;
      8'h30:   r.idx = 4'd3;
      8'h38:   r.idx = 4'd4;
      8'h48:   r.idx = 4'd5;
      8'h4C:   r.idx = 4'd6;
      8'h50:   r.idx = 4'd7;
      8'h54:   r.idx = 4'd8;
      8'h58:   r.idx = 4'd9;
      default: begin r.hit = 1'b0; r.idx = '0; end
    endcase
    return r;
  endfunction

  function automatic dir_hit_t dir_lookup(input logic [ADDR_W-1:0] a);
    dir_hit_t r;
    r.hit = 1'b1;
    case (a)
      8'h00:   r.idx = 4'd0;
      8'h10:   r.idx = 4'd1;
      8'h14:   r.idx = 4'd2;
      8'h18:   r.idx = 4'd3;
      8'h1C:   r.idx = 4'd4;
      8'h20:   r.idx = 4'd5;
      8'h3C:   r.idx = 4'd6;
      8'h44:   r.idx = 4'd7;
      8'h40:   r.idx = 4'd8;
      default: begin r.hit = 1'b0; r.idx = '0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/prb_rst_sync.sv
module prb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic fclk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge fclk) begin
    sh <= {sh[STAGES-2:0], rst_in};
  end

  assign rst_out = sh[STAGES-1];
endmodule

// File: rtl/prb_channel.sv
module prb_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          pend,
  output logic [DW-1:0] hold,
  input  logic          fclk,
  input  logic          frst,
  output logic          f_stb,
  output logic [DW-1:0] f_q
);
  logic req_t, ack_s1, ack_s2;
  logic ack_t, r1, r2, r3;
  logic chg;

  // bus side: holding register and request toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      req_t  <= 1'b0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      hold   <= '0;
    end else begin
      ack_s1 <= ack_t;
      ack_s2 <= ack_s1;
      if (load) begin
        hold  <= din;
        req_t <= ~req_t;
      end
    end
  end

  assign pend = req_t ^ ack_s2;

  // slow side: synchronise request, capture, acknowledge
  assign chg = r2 ^ r3;

  always_ff @(posedge fclk) begin
    if (frst) begin
      r1    <= 1'b0;
      r2    <= 1'b0;
      r3    <= 1'b0;
      ack_t <= 1'b0;
      f_stb <= 1'b0;
      f_q   <= '0;
    end else begin
      r1    <= req_t;
      r2    <= r1;
      r3    <= r2;
      f_stb <= chg;
      if (chg) begin
        f_q   <= hold;
        ack_t <= r2;
      end
    end
  end

  // R4: the parent never loads a register that still has a write in flight
  assert_load_idle_R4: assert property (@(posedge clk) disable iff (rst)
    load |-> !pend);

  // R3: holding data is frozen while the slow side may sample it
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (pend && !load) |=> $stable(hold));

  // R3: each delivery is a single slow-cycle pulse
  assert_strobe_pulse_R3: assert property (@(posedge fclk) disable iff (frst)
    f_stb |=> !f_stb);
endmodule

// File: rtl/posted_reg_bridge.sv
module posted_reg_bridge
  import prb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_valid,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  bus_ready,
  input  logic                  fclk,
  output logic [NSYNC-1:0]      f_strobe,
  output logic [NSYNC*DW-1:0]   f_data,
  output logic                  wr_drop_err,
  output logic                  rd_pend_err
);
  localparam logic [DW-1:0] IFC_RESET = DW'(1) << POSTED_BIT;

  sync_hit_t          sh;
  dir_hit_t           dh;
  logic [NSYNC-1:0]   pend_vec;
  logic [NSYNC-1:0]   load_vec;
  logic [DW-1:0]      hold_arr [NSYNC];
  logic [DW-1:0]      dreg     [NDIR];
  logic               frst;
  logic               posted, wr_sync, rd_sync, cur_pend;
  logic               load_any, drop, np_busy;

  assign sh       = sync_lookup(bus_addr);
  assign dh       = dir_lookup(bus_addr);
  assign posted   = dreg[IFC_IDX][POSTED_BIT];
  assign wr_sync  = bus_valid && bus_we && sh.hit;
  assign rd_sync  = bus_valid && !bus_we && sh.hit;
  assign cur_pend = sh.hit && pend_vec[sh.idx];
  assign load_any = wr_sync && !cur_pend && !np_busy;
  assign drop     = wr_sync && posted && cur_pend;

  always_comb begin
    if (wr_sync && !posted) bus_ready = np_busy && !cur_pend;
    else                    bus_ready = 1'b1;
  end

  prb_rst_sync #(.STAGES(2)) u_rsync (
    .fclk(fclk), .rst_in(rst), .rst_out(frst)
  );

  for (genvar i = 0; i < NSYNC; i++) begin : g_ch
    assign load_vec[i] = load_any && (sh.idx == SIDX_W'(i));
    prb_channel #(.DW(DW)) u_ch (
      .clk  (clk),
      .rst  (rst),
      .load (load_vec[i]),
      .din  (bus_wdata),
      .pend (pend_vec[i]),
      .hold (hold_arr[i]),
      .fclk (fclk),
      .frst (frst),
      .f_stb(f_strobe[i]),
      .f_q  (f_data[i*DW +: DW])
    );
  end

  // non-posted stall tracking and sticky errors
  always_ff @(posedge clk) begin
    if (rst) begin
      np_busy     <= 1'b0;
      wr_drop_err <= 1'b0;
      rd_pend_err <= 1'b0;
    end else begin
      if (wr_sync && !posted) begin
        if (np_busy && bus_ready) np_busy <= 1'b0;
        else if (load_any)        np_busy <= 1'b1;
      end
      if (drop)                 wr_drop_err <= 1'b1;
      if (rd_sync && cur_pend)  rd_pend_err <= 1'b1;
    end
  end

  // directly written registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NDIR; j++)
        dreg[j] <= (j == IFC_IDX) ? IFC_RESET : '0;
    end else if (bus_valid && bus_we && dh.hit) begin
      dreg[dh.idx] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == STAT_ADDR) bus_rdata = DW'(pend_vec);
    else if (sh.hit)           bus_rdata = hold_arr[sh.idx];
    else if (dh.hit)           bus_rdata = dreg[dh.idx];
  end

  assert_posted_nostall_R2: assert property (@(posedge clk) disable iff (rst)
    posted |-> bus_ready);

  assert_pend_set_R2: assert property (@(posedge clk) disable iff (rst)
    load_any |=> pend_vec[$past(sh.idx)]);

  assert_drop_flag_R4: assert property (@(posedge clk) disable iff (rst)
    drop |=> wr_drop_err);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    wr_drop_err |=> wr_drop_err);

  assert_rd_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_sync && cur_pend) |=> rd_pend_err);

  assert_np_done_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_sync && !posted && bus_ready) |-> !cur_pend);
endmodule

// File: tb/posted_reg_bridge_test.sv
module posted_reg_bridge_test;
  localparam int DW = 32;

  logic            clk = 1'b0, fclk = 1'b0, rst = 1'b1;
  logic            bus_valid = 1'b0, bus_we = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [DW-1:0]   bus_rdata;
  logic            bus_ready;
  logic [9:0]      f_strobe;
  logic [10*DW-1:0] f_data;
  logic            wr_drop_err, rd_pend_err;

  int total = 0, bad = 0;
  int scnt [10];
  logic [31:0] slast [10];
  bit done = 0;

  always #10 clk = ~clk;
  always #85 fclk = ~fclk;

  posted_reg_bridge #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .fclk(fclk), .f_strobe(f_strobe),
    .f_data(f_data), .wr_drop_err(wr_drop_err), .rd_pend_err(rd_pend_err)
  );

  initial for (int i = 0; i < 10; i++) begin scnt[i] = 0; slast[i] = '0; end

  always @(negedge fclk) begin
    if (!rst) begin
      for (int i = 0; i < 10; i++) begin
        if (f_strobe[i]) begin
          scnt[i]++;
          slast[i] = f_data[i*DW +: DW];
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output int stalls);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    stalls = 0;
    #1;
    while (!bus_ready && stalls < 3000) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic wait_clear(input logic [31:0] mask, input string req);
    logic [31:0] s;
    int n = 0;
    bus_read(8'h34, s);
    while ((s & mask) != 0 && n < 2000) begin
      n++;
      bus_read(8'h34, s);
    end
    check(req, 32'(n <= 60), 32'd1);
    #600;
  endtask

  function automatic int strobe_sum();
    int s = 0;
    for (int i = 0; i < 10; i++) s += scnt[i];
    return s;
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    check("R1 ready", 32'(bus_ready), 32'd1);
    check("R1 wr_err", 32'(wr_drop_err), 32'd0);
    check("R1 rd_err", 32'(rd_pend_err), 32'd0);
    bus_read(8'h34, d); check("R1 status", d, 32'h0);
    bus_read(8'h40, d); check("R1 mode", d, 32'h4);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    int st, base;
    base = strobe_sum();
    bus_write(8'h1C, 32'hABCD_0123, st); check("R7 nostall", 32'(st), 32'd0);
    bus_read(8'h1C, d); check("R7 readback 1C", d, 32'hABCD_0123);
    bus_write(8'h44, 32'h5555_AAAA, st);
    bus_read(8'h44, d); check("R7 readback 44", d, 32'h5555_AAAA);
    bus_read(8'h34, d); check("R7 no pending", d, 32'h0);
    bus_write(8'h34, 32'h0000_03FF, st);
    bus_read(8'h34, d); check("R10 status ro", d, 32'h0);
    bus_read(8'h28, d);
    @(negedge clk); check("R5 idle read no err", 32'(rd_pend_err), 32'd0);
    #600;
    check("R7 R10 no strobe", 32'(strobe_sum()), 32'(base));
  endtask

  task automatic t_posted();
    logic [31:0] d;
    int st;
    bus_write(8'h2C, 32'h1234_5678, st); check("R2 nostall", 32'(st), 32'd0);
    bus_read(8'h34, d); check("R2 pending bit2", d, 32'h4);
    wait_clear(32'h4, "R3 clear bound");
    check("R3 strobe count", 32'(scnt[2]), 32'd1);
    check("R3 strobe data", slast[2], 32'h1234_5678);
    bus_read(8'h2C, d); check("R9 readback", d, 32'h1234_5678);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    int st;
    bus_write(8'h48, 32'h0000_1111, st);
    bus_write(8'h4C, 32'h0000_2222, st);
    bus_write(8'h58, 32'h0000_3333, st);
    bus_read(8'h34, d); check("R8 three flags", d, 32'h260);
    wait_clear(32'h260, "R8 clear bound");
    check("R8 cnt5", 32'(scnt[5]), 32'd1);
    check("R8 cnt6", 32'(scnt[6]), 32'd1);
    check("R8 cnt9", 32'(scnt[9]), 32'd1);
    check("R8 data5", slast[5], 32'h0000_1111);
    check("R8 data6", slast[6], 32'h0000_2222);
    check("R8 data9", slast[9], 32'h0000_3333);
  endtask

  task automatic t_rderr();
    logic [31:0] d;
    int st;
    bus_write(8'h24, 32'hCAFE_0001, st);
    bus_read(8'h24, d);
    @(negedge clk); check("R5 read pending err", 32'(rd_pend_err), 32'd1);
    wait_clear(32'h1, "R5 clear bound");
  endtask

  task automatic t_drop();
    logic [31:0] d;
    int st;
    @(negedge clk); check("R4 no err before", 32'(wr_drop_err), 32'd0);
    bus_write(8'h38, 32'hAAAA_0001, st);
    bus_write(8'h38, 32'hBBBB_0002, st); check("R4 drop nostall", 32'(st), 32'd0);
    @(negedge clk); check("R4 err set", 32'(wr_drop_err), 32'd1);
    wait_clear(32'h10, "R4 clear bound");
    check("R4 one delivery", 32'(scnt[4]), 32'd1);
    check("R4 first value kept", slast[4], 32'hAAAA_0001);
    bus_read(8'h38, d); check("R4 hold kept", d, 32'hAAAA_0001);
    repeat (5) @(negedge clk);
    check("R4 err sticky", 32'(wr_drop_err), 32'd1);
  endtask

  task automatic t_nonposted();
    logic [31:0] d;
    int st;
    bus_write(8'h40, 32'h0, st);
    bus_read(8'h40, d); check("R6 mode np", d, 32'h0);
    bus_write(8'h30, 32'h7777_0003, st);
    check("R6 stalled", 32'(st > 5 && st <= 60), 32'd1);
    bus_read(8'h34, d); check("R6 clear at done", d, 32'h0);
    #600;
    check("R6 delivered", 32'(scnt[3]), 32'd1);
    check("R6 data", slast[3], 32'h7777_0003);
    bus_write(8'h20, 32'h0000_00F0, st); check("R7 np direct nostall", 32'(st), 32'd0);
    bus_write(8'h40, 32'h4, st);
    bus_read(8'h40, d); check("R6 mode restored", d, 32'h4);
  endtask

  initial begin
    repeat (50) @(posedge clk);
    #1 rst = 1'b0;
    repeat (30) @(posedge clk);
    t_reset();
    t_direct();
    t_posted();
    t_multi();
    t_rderr();
    t_drop();
    t_nonposted();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule